// File: doc/BRIEF.md
# Single-Fault Test Vector Finder

This block models a tiny three-input logic cone, z = x1·x2 + x2·x3, built from two AND gates (internal outputs `a` and `b`) that feed one OR gate. It holds two copies of the cone: one that is always fault-free and one into which a single selectable defect is injected. The defect is either one line held at a constant 0 or 1, or a short between the two AND outputs in which one logic value dominates.

A one-cycle start pulse latches the fault code and launches a sweep of all eight input combinations, one per clock. Each combination on which the two copies disagree is a test for the chosen fault and is recorded in an 8-bit mask. When the sweep ends a one-cycle done strobe is raised. The mask, the lowest-numbered detecting combination and a flag that says whether any detecting combination exists stay stable until the next accepted start. The block serves to build the test set for one fault at a time, or to show that a fault cannot be detected at the output.

Top module: `fault_sweep`

## Requirements
- R1: After reset, `mask` is 0, `done` is 0, `first_ok` is 0 and `first_vec` is 0.
- R2: Fault code 0 and every code from 19 to 31 inject nothing, so the sweep ends with `mask` equal to 0 and `first_ok` low.
- R3: Codes 1 to 16 hold one line stuck: the line index is (code-1)>>1 and the stuck value is bit 0 of (code-1). Line indices are 0 x1, 1 x2 before its fanout, 2 x3, 3 the x2 branch into the x1 AND gate, 4 the x2 branch into the x3 AND gate, 5 the output `a` of the x1 AND gate, 6 the output `b` of the x3 AND gate, 7 the output z.
- R4: Bit i of `mask` is 1 exactly when the fault-free and faulty outputs differ for input combination i, where x1 is bit 2 of i, x2 is bit 1 and x3 is bit 0 (for example, x2 stuck at 1 marks combination 1, which is x1=0, x2=0, x3=1).
- R5: Code 17 shorts `a` and `b` with AND dominance (both take a·b); code 18 shorts them with OR dominance (both take a+b).
- R6: If `start` is high at clock edge E0, combination i is evaluated at edge E(i+1), and `done` is high for exactly the one cycle that follows edge E8.
- R7: After a sweep, `mask` and the first-test outputs hold their values until the next accepted start, whatever `fault_sel` does meanwhile.
- R8: The fault code is taken from `fault_sel` only at an accepted start; a `start` pulse during a sweep is ignored and the sweep keeps its original fault code and timing.
- R9: `first_vec` gives the lowest index set in `mask`, and `first_ok` is high exactly when `mask` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sweep |
| fault_sel | input | 5 | Fault code, latched at an accepted start |
| mask | output | 8 | Per-combination detection result |
| first_vec | output | 3 | Lowest detecting combination |
| first_ok | output | 1 | High when at least one combination detects the fault |
| done | output | 1 | One-cycle strobe at the end of a sweep |

## Verification
The assertions assume `start` is a clean synchronous level that may arrive at any cycle, including during a sweep, and that `fault_sel` may change freely between starts. The stimulus drives both only on the falling clock edge, so every value is stable around each rising edge. It deliberately raises `start` mid-sweep and moves `fault_sel` after a sweep to exercise the ignore and hold rules, and it covers every defined fault code plus an unused one.

// File: rtl/fault_sweep.sv
module fault_sweep (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [4:0] fault_sel,
  output logic [7:0] mask,
  output logic [2:0] first_vec,
  output logic       first_ok,
  output logic       done
);

  logic [4:0] code_q;
  logic [2:0] idx;
  logic       busy;

  logic [4:0] code_m1;
  logic       is_stuck, sv, br_and, br_or;
  logic [7:0] hit;
  logic       x1, x2, x3, g_z;
  logic       f_x1, f_x2, f_x3, f_br1, f_br2, fa0, fb0, fa, fb, f_z;

  assign code_m1  = code_q - 5'd1;
  assign is_stuck = (code_q >= 5'd1) && (code_q <= 5'd16);
  assign sv       = code_m1[0];
  assign hit      = is_stuck ? (8'b1 << code_m1[3:1]) : 8'b0;
  assign br_and   = (code_q == 5'd17);
  assign br_or    = (code_q == 5'd18);

  assign {x1, x2, x3} = idx;
  assign g_z = (x1 & x2) | (x2 & x3);

  assign f_x1  = hit[0] ? sv : x1;
  assign f_x2  = hit[1] ? sv : x2;
  assign f_x3  = hit[2] ? sv : x3;
  assign f_br1 = hit[3] ? sv : f_x2;
  assign f_br2 = hit[4] ? sv : f_x2;
  assign fa0   = hit[5] ? sv : (f_x1 & f_br1);
  assign fb0   = hit[6] ? sv : (f_br2 & f_x3);
  assign fa    = br_and ? (fa0 & fb0) : br_or ? (fa0 | fb0) : fa0;
  assign fb    = br_and ? (fa0 & fb0) : br_or ? (fa0 | fb0) : fb0;
  assign f_z   = hit[7] ? sv : (fa | fb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx    <= '0;
      busy   <= 1'b0;
      mask   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        mask[idx] <= g_z ^ f_z;
        idx       <= idx + 3'd1;
        if (idx == 3'd7) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        code_q <= fault_sel;
        idx    <= '0;
        mask   <= '0;
        busy   <= 1'b1;
      end
    end
  end

  always_comb begin
    first_vec = '0;
    for (int i = 7; i >= 0; i--)
      if (mask[i]) first_vec = 3'(i);
  end
  assign first_ok = |mask;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_sweep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));
  assert_nofault_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (code_q == 5'd0)) |-> (mask == 8'd0));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(code_q));
  assert_mask_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(mask));
  assert_first_points_R9: assert property (@(posedge clk) disable iff (!rst_n)
    first_ok |-> mask[first_vec]);

endmodule

// File: tb/fault_sweep_test.sv
module fault_sweep_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] fault_sel = '0;
  logic [7:0] mask;
  logic [2:0] first_vec;
  logic       first_ok;
  logic       done;

  int checks = 0;
  int fails  = 0;
  bit hung   = 1'b0;

  fault_sweep uut (.clk(clk), .rst_n(rst_n), .start(start), .fault_sel(fault_sel),
                   .mask(mask), .first_vec(first_vec), .first_ok(first_ok), .done(done));

  always #4 clk = ~clk;

  // {code, expected mask}
  localparam logic [12:0] VECS [20] = '{
    {5'd1, 8'h40}, {5'd2, 8'h04}, {5'd3, 8'hC8}, {5'd4, 8'h32},
    {5'd5, 8'h08}, {5'd6, 8'h04}, {5'd7, 8'h40}, {5'd8, 8'h30},
    {5'd9, 8'h08}, {5'd10, 8'h22}, {5'd11, 8'h40}, {5'd12, 8'h37},
    {5'd13, 8'h08}, {5'd14, 8'h37}, {5'd15, 8'hC8}, {5'd16, 8'h37},
    {5'd17, 8'h48}, {5'd18, 8'h00}, {5'd0, 8'h00}, {5'd25, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_first(input string req, input logic [7:0] m);
    int lo = 0;
    for (int i = 7; i >= 0; i--) if (m[i]) lo = i;
    check(req, first_ok, (m != 0));
    if (m != 0) check(req, first_vec, lo);
  endtask

  // start at a negedge, then count negedges until done; return count
  task automatic sweep(input logic [4:0] code, output int lat);
    fault_sel = code;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(8 * 20000);
    hung = 1'b1;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mask", mask, 0);
    check("R1 done", done, 0);
    check("R1 first_ok", first_ok, 0);
    check("R1 first_vec", first_vec, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 20; k++) begin
      logic [4:0] code;
      logic [7:0] em;
      code = VECS[k][12:8];
      em   = VECS[k][7:0];
      sweep(code, lat);
      if (code == 0 || code > 18) check("R2 zero mask", mask, 0);
      else if (code >= 17) check("R5 bridge mask", mask, em);
      else check("R3 R4 stuck mask", mask, em);
      check_first("R9 first test", em);
      if (hung) break;
    end

    // R6 timing: done seen exactly at negedge 9 after start set, one cycle wide
    sweep(5'd4, lat);
    check("R6 done latency", lat, 9);
    check("R4 x2 stuck1 flags vector 1", mask[1], 1);
    @(negedge clk);
    check("R6 done width", done, 0);

    // R7 hold after sweep while fault_sel moves
    fault_sel = 5'd12;
    repeat (5) @(negedge clk);
    check("R7 mask held", mask, 8'h32);
    check("R7 first held", first_vec, 1);

    // R8 start during sweep ignored
    fault_sel = 5'd17;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fault_sel = 5'd12;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R8 original timing", lat, 9);
    check("R8 original code", mask, 8'h48);
    repeat (3) @(negedge clk);
    check("R8 no restart", mask, 8'h48);

    if (hung) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule